// File: doc/BRIEF.md
# Comparator Output Digital Filter

This block conditions the single raw bit produced by an analog comparator before logic or a device pin uses it. The raw bit can be inverted first. The result is the unfiltered value. A small digital filter samples that value, either on a timebase counted in bus clocks or on the rising edges of an external sample strobe. The filtered output changes only after a programmed number of consecutive samples agree.

A windowing control can stop the filter from taking samples, which freezes the filtered output. A final selector drives the output pin from either the filtered or the unfiltered value, and a pin enable forces the pin low. A module enable clears all filter state. The comparator bit and the strobe are taken as synchronous to `clk`.

Top module: `cmp_out_filter`

## Requirements
- R1: While reset is asserted, and after it is released with `enable` low, `out_unfiltered`, `out_filtered` and `pin_out` are all 0.
- R2: `out_unfiltered` equals `enable & (cmp_raw ^ invert)` in the same cycle, with no register on the path.
- R3: With `ext_sample_mode` = 0 and `sample_period` = P, where P is not 0, one sample is taken every P clock edges. The first sample falls on the P-th edge after P is applied. With P = 0 no sample is taken and `out_filtered` holds.
- R4: With `ext_sample_mode` = 1, the period counter is not used. Each rising edge of `sample_strobe` is one sample, taken at the first clock edge on which the strobe is seen high. Holding the strobe high for many cycles still gives only one sample.
- R5: With `agree_count` = N (1 to 7), `out_filtered` takes the sampled value at the sample that completes N consecutive equal samples. A sample that differs from the previous one restarts the run at one. Between samples, `out_filtered` holds.
- R6: With `agree_count` = 0 the filter is bypassed. `out_filtered` equals `out_unfiltered` when `ext_sample_mode` = 0 and is 0 when `ext_sample_mode` = 1.
- R7: With `window_en` = 1 and `window_open` = 0, samples are discarded and the filtered value holds. With `window_open` = 1, or with `window_en` = 0, samples are taken normally.
- R8: `pin_out` equals `pin_enable & (pin_select_raw ? out_unfiltered : out_filtered)`.
- R9: While `enable` = 0, the filter state clears at each clock edge, so that `out_filtered` reads 0. After the block is re-enabled, a full run of agreeing samples is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; 0 clears the filter |
| invert | input | 1 | Invert the raw comparator bit |
| cmp_raw | input | 1 | Raw comparator result |
| ext_sample_mode | input | 1 | 1: sample on strobe edges; 0: sample on the period counter |
| sample_strobe | input | 1 | External sample strobe |
| window_en | input | 1 | Enable windowing |
| window_open | input | 1 | Window active; samples allowed |
| agree_count | input | CNT_W (3) | Consecutive samples needed; 0 bypasses |
| sample_period | input | PER_W (8) | Internal sample interval in clocks; 0 stops sampling |
| pin_select_raw | input | 1 | Pin source: 0 filtered, 1 unfiltered |
| pin_enable | input | 1 | Gates the pin output |
| out_unfiltered | output | 1 | Inverted-or-not raw result |
| out_filtered | output | 1 | Filtered result |
| pin_out | output | 1 | Output pin value |

## Verification
`out_unfiltered`, `pin_out` and the bypass value of `out_filtered` follow their inputs in the same cycle. A filtered update appears after the clock edge on which the sample is taken. For an external strobe, that is the first edge at which the strobe is high. For the period counter, it is the P-th edge after the period is set. The bench changes inputs on the falling clock edge and compares outputs at the next falling edge, so each result is checked exactly one rising edge after its stimulus. The directed cases count pulses and edges to land on the sample that completes a run, and a bench model stepped on the rising edge supplies the expected values for the random phase.

// File: rtl/cof_pkg.sv
package cof_pkg;
  parameter int unsigned DEF_PER_W = 8;
  parameter int unsigned DEF_CNT_W = 3;

  typedef enum logic {
    SRC_PERIOD = 1'b0,
    SRC_STROBE = 1'b1
  } sample_src_e;
endpackage

// File: rtl/cof_tick_gen.sv
module cof_tick_gen
  import cof_pkg::*;
#(
  parameter int unsigned PER_W = DEF_PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ext_mode,
  input  logic [PER_W-1:0] period,
  input  logic             strobe,
  output logic             tick
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  sample_src_e      src;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             strobe_q;
  logic             per_run, int_hit, ext_hit;

  always_comb begin
    src     = sample_src_e'(ext_mode);
    per_run = en && (src == SRC_PERIOD) && (period != '0);
    int_hit = per_run && (cnt_q >= (period - ONE));
    ext_hit = en && (src == SRC_STROBE) && strobe && !strobe_q;
    tick    = int_hit || ext_hit;
    if (!per_run || int_hit) cnt_d = '0;
    else                     cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      strobe_q <= strobe;
    end
  end

  // R3: a zero period never produces an internal sample
  p_no_tick_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ext_mode && period == '0) |-> !tick);

  // R4: one strobe edge cannot give samples on two consecutive edges
  p_ext_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ext_mode && tick) |=> (!tick || !ext_mode));
endmodule

// File: rtl/cof_agree_filter.sv
module cof_agree_filter
  import cof_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sample_ok,
  input  logic             smp,
  input  logic [CNT_W-1:0] need,
  output logic             filt_q
);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

  logic             cand_q, cand_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic             filt_d;

  always_comb begin
    cand_d = cand_q;
    run_d  = run_q;
    filt_d = filt_q;
    if (!en) begin
      cand_d = 1'b0;
      run_d  = '0;
      filt_d = 1'b0;
    end else if (sample_ok && need != '0) begin
      cand_d = smp;
      if (smp != cand_q)       run_d = RUN_ONE;
      else if (run_q == RUN_MAX) run_d = RUN_MAX;
      else                     run_d = run_q + RUN_ONE;
      if (run_d >= need) filt_d = smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      run_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cand_q <= cand_d;
      run_q  <= run_d;
      filt_q <= filt_d;
    end
  end

  // R5: without a sample the filtered value holds
  p_hold_no_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sample_ok) |=> $stable(filt_q));

  // R9: a disabled block clears its filter state
  p_clear_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (filt_q == 1'b0 && run_q == '0));
endmodule

// File: rtl/cmp_out_filter.sv
module cmp_out_filter
  import cof_pkg::*;
#(
  parameter int unsigned PER_W = DEF_PER_W,
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             invert,
  input  logic             cmp_raw,
  input  logic             ext_sample_mode,
  input  logic             sample_strobe,
  input  logic             window_en,
  input  logic             window_open,
  input  logic [CNT_W-1:0] agree_count,
  input  logic [PER_W-1:0] sample_period,
  input  logic             pin_select_raw,
  input  logic             pin_enable,
  output logic             out_unfiltered,
  output logic             out_filtered,
  output logic             pin_out
);
  logic tick, sample_ok, filt_q, bypass;

  cof_tick_gen #(.PER_W(PER_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .ext_mode (ext_sample_mode),
    .period   (sample_period),
    .strobe   (sample_strobe),
    .tick     (tick)
  );

  always_comb begin
    out_unfiltered = enable & (cmp_raw ^ invert);
    sample_ok      = tick & (~window_en | window_open);
    bypass         = (agree_count == '0);
  end

  cof_agree_filter #(.CNT_W(CNT_W)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .sample_ok (sample_ok),
    .smp       (out_unfiltered),
    .need      (agree_count),
    .filt_q    (filt_q)
  );

  always_comb begin
    if (bypass) out_filtered = ext_sample_mode ? 1'b0 : out_unfiltered;
    else        out_filtered = filt_q;
    pin_out = pin_enable & (pin_select_raw ? out_unfiltered : out_filtered);
  end

  // R8: a disabled pin stays low
  p_pin_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_enable |-> !pin_out);

  // R6: bypass with external sampling reads zero
  p_bypass_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (agree_count == '0 && ext_sample_mode) |-> !out_filtered);

  // R9: a disabled block shows no comparator result
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !out_unfiltered);
endmodule

// File: tb/sim_cmp_out_filter.sv
module sim_cmp_out_filter;
  localparam int CLK_PERIOD = 10;
  localparam int PER_W = 8;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, inv = 0, raw = 0, sm = 0, stb = 0, we = 0, wi = 0, osel = 0, pen = 0;
  logic [CNT_W-1:0] need = '0;
  logic [PER_W-1:0] per = '0;
  logic unf, filt, pin;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_out_filter #(.PER_W(PER_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(en), .invert(inv), .cmp_raw(raw),
    .ext_sample_mode(sm), .sample_strobe(stb), .window_en(we), .window_open(wi),
    .agree_count(need), .sample_period(per), .pin_select_raw(osel),
    .pin_enable(pen), .out_unfiltered(unf), .out_filtered(filt), .pin_out(pin)
  );

  // Bench model built from the requirements
  logic [PER_W-1:0] m_cnt;
  logic m_sq, m_cand, m_filt;
  int m_run;
  logic m_tick, m_smp;
  int m_nrun;

  function automatic logic e_unf();
    return en & (raw ^ inv);
  endfunction
  function automatic logic e_filt();
    if (need == '0) return sm ? 1'b0 : e_unf();
    return m_filt;
  endfunction
  function automatic logic e_pin();
    return pen & (osel ? e_unf() : e_filt());
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_sq <= 0; m_cand <= 0; m_run <= 0; m_filt <= 0;
    end else begin
      m_tick = 0;
      if (en && !sm && per != 0 && int'(m_cnt) + 1 >= int'(per)) m_tick = 1;
      if (en && sm && stb && !m_sq) m_tick = 1;
      if (!en || sm || per == 0 || m_tick) m_cnt <= '0;
      else m_cnt <= m_cnt + 1'b1;
      m_sq <= stb;
      if (!en) begin
        m_cand <= 0; m_run <= 0; m_filt <= 0;
      end else if (m_tick && (!we || wi) && need != 0) begin
        m_smp = e_unf();
        m_nrun = (m_smp != m_cand) ? 1 : ((m_run >= 7) ? 7 : m_run + 1);
        m_cand <= m_smp;
        m_run <= m_nrun;
        if (m_nrun >= int'(need)) m_filt <= m_smp;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    stb = 1; step(1); stb = 0; step(1);
  endtask

  initial begin
    step(3);
    chk("R1 unfiltered in reset", unf, 1'b0);
    chk("R1 filtered in reset", filt, 1'b0);
    rst_n = 1;
    raw = 1; pen = 1;
    step(1);
    chk("R1 unfiltered disabled", unf, 1'b0);
    chk("R1 filtered after reset", filt, 1'b0);
    chk("R1 pin after reset", pin, 1'b0);

    // external strobe, run of 3
    en = 1; need = 3; sm = 1; step(1);
    chk("R2 unfiltered follows raw", unf, 1'b1);
    pulse(); pulse();
    chk("R5 two of three samples", filt, 1'b0);
    pulse();
    chk("R5 third sample flips", filt, 1'b1);
    chk("R8 pin follows filtered", pin, 1'b1);
    raw = 0; pulse(); raw = 1; pulse();
    raw = 0; pulse(); pulse();
    chk("R5 run restarted by mismatch", filt, 1'b1);
    pulse();
    chk("R5 restarted run completes", filt, 1'b0);
    // a long strobe counts once
    raw = 1; stb = 1; step(5); stb = 0; step(1);
    stb = 1; step(5); stb = 0; step(1);
    chk("R4 held strobe is one sample", filt, 1'b0);
    pulse();
    chk("R4 third edge completes run", filt, 1'b1);

    // bypass
    need = 0; step(1);
    chk("R6 bypass with strobe mode is zero", filt, 1'b0);
    sm = 0; step(1);
    chk("R6 bypass follows unfiltered", filt, 1'b1);
    inv = 1; step(1);
    chk("R2 invert unfiltered", unf, 1'b0);
    chk("R6 bypass follows inverted", filt, 1'b0);

    // windowing, run of 1
    inv = 0; need = 1; sm = 1; raw = 0; pulse(); raw = 1; pulse();
    chk("R5 single sample", filt, 1'b1);
    we = 1; wi = 0; raw = 0; pulse();
    chk("R7 closed window holds", filt, 1'b1);
    wi = 1; pulse();
    chk("R7 open window samples", filt, 1'b0);
    we = 0; wi = 0;

    // pin source and gating
    osel = 1; raw = 1; step(1);
    chk("R8 pin from unfiltered", pin, 1'b1);
    chk("R8 filtered unchanged", filt, 1'b0);
    pen = 0; step(1);
    chk("R8 pin disabled", pin, 1'b0);
    pen = 1; osel = 0;

    // internal period
    sm = 0; per = 0; step(20);
    chk("R3 zero period holds", filt, 1'b0);
    per = 5; step(4);
    chk("R3 no sample before 5th edge", filt, 1'b0);
    step(1);
    chk("R3 sample on 5th edge", filt, 1'b1);

    // enable clears
    en = 0; per = 0; step(1);
    chk("R9 disabled clears filtered", filt, 1'b0);
    en = 1; need = 2; sm = 1; step(1);
    pulse();
    chk("R9 re-enable needs full run", filt, 1'b0);
    pulse();
    chk("R9 run after re-enable", filt, 1'b1);

    // random phase against the model
    void'($urandom(32'h5eed_c0f1));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R2 random unfiltered", unf, e_unf());
      chk("R5 random filtered", filt, e_filt());
      chk("R8 random pin", pin, e_pin());
      raw = ($urandom_range(0, 3) != 0) ? raw : ~raw;
      stb = $urandom_range(0, 1);
      wi  = $urandom_range(0, 1);
      if ($urandom_range(0, 99) < 3) begin
        en   = ($urandom_range(0, 9) != 0);
        inv  = $urandom_range(0, 1);
        sm   = $urandom_range(0, 1);
        we   = $urandom_range(0, 1);
        need = CNT_W'($urandom_range(0, 7));
        per  = PER_W'($urandom_range(0, 6));
        osel = $urandom_range(0, 1);
        pen  = ($urandom_range(0, 4) != 0);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule